// File: doc/BRIEF.md
# Two-Phase Read Serial Master

This block is a serial bus master for frequency-synthesiser slaves that share a single return-data line. Every slave has its own active-high enable line. The block takes one command at a time on a valid/ready request port. A write command is sent as a single 32-bit frame. A read command is sent as an address frame, then a pause with the enable low, then a 33-edge data window. From that window the master collects the slave's lock flag and the 32-bit register value. It reports both on a response strobe.

The serial clock idles high. Outgoing data changes on the falling edge. Return data is sampled on the rising edge, which keeps the master's hold time short of the slave's output delay. A slave that has been addressed keeps driving the shared return line. When a command names a different slave, the master therefore first sends the previously addressed slave a frame whose chip field is not zero, and that slave then releases the line.

The design is a state machine with eight states:

| State | What it does |
|---|---|
| ST_IDLE | Accepts a command. |
| ST_RELEASE | Sends the release frame. |
| ST_REL_GAP | Pause after the release frame. |
| ST_WRITE | Sends the write frame. |
| ST_RD_ADDR | Sends the read address frame. |
| ST_RD_GAP | Enable low between the two read phases. |
| ST_RD_DATA | The 33-edge data window. |
| ST_TAIL | Pause after the last frame, then back to idle. |

The transitions are:

| Transition | Condition |
|---|---|
| IDLE→RELEASE | A command names a slave other than the last one addressed. |
| IDLE→WRITE | A write to the same slave, or the first command after reset. |
| IDLE→RD_ADDR | A read to the same slave, or the first command after reset. |
| RELEASE→REL_GAP | The release frame is done. |
| REL_GAP→WRITE or REL_GAP→RD_ADDR | The pause has expired. |
| WRITE→TAIL | The frame is done; a response is issued. |
| RD_ADDR→RD_GAP | The address frame is done. |
| RD_GAP→RD_DATA | The pause has expired. |
| RD_DATA→TAIL | The data window is done; a response is issued. |
| TAIL→IDLE | The pause has expired. |

Top module: `twophase_spi_master`

## Requirements
- R1: `sclk` is high in every cycle in which no `slv_en` bit is set. `sclk` is also high in the cycle in which an enable rises and in the cycle in which it falls.
- R2: While an enable is high, every high run and every low run of `sclk` lasts exactly CLK_DIV/2 system clocks. `mosi` changes only at a falling edge of `sclk`.
- R3: A write produces one enable window of 32 rising edges. The frame, sent MSB first, is {cmd_wdata[23:0], cmd_reg[4:0], 3'b000}.
- R4: A read produces two windows to the same slave, in this order:
  - An address window of 32 edges carrying {19'b0, cmd_reg[4:0], 5'b00000, 3'b000}.
  - After the enable has been low, a data window of 33 edges. During this window `mosi` repeats the address word on the first 32 edges and is 0 on the 33rd.
- R5: In the data window `miso` is sampled at each rising edge. The first sample is `rsp_lock`, and the next 32 samples are `rsp_data` from bit 31 down to bit 0. The response has `rsp_is_read`=1.
- R6: `rsp_valid` is a one-cycle pulse issued after the last frame of a command. For a write, `rsp_is_read`=0, `rsp_lock`=0 and `rsp_data`=0.
- R7: At most one `slv_en` bit is high at a time. The bit that is high is the slave being addressed.
- R8: Between any two enable windows all enables stay low for at least GAP_CYC system clocks.
- R9: When a command names a slave other than the last slave addressed, a release window goes first to that last slave. The release window carries the word 32'h0000_0007, with the chip field set to 3'b111. There is no release for the first command after reset, nor for a command to the same slave.
- R10: `cmd_ready` is high only in the idle state. It is low while any enable is high, and it stays low from acceptance until after the response.
- R11: After reset, `cmd_ready`=1, `sclk`=1, `mosi`=0, every `slv_en` bit is 0 and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high together with valid |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_slave | input | SW (2) | Index of the target slave |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 24 | Write payload (ignored for reads) |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_is_read | output | 1 | Response belongs to a read |
| rsp_lock | output | 1 | Lock flag captured on the first data edge |
| rsp_data | output | 32 | Read word |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data to the slaves |
| miso | input | 1 | Shared return data from the slaves |
| slv_en | output | NUM_SLV (4) | One active-high enable per slave |

## Verification
The hardest case to reach is the release of the shared return line. It appears only when a command follows an earlier one to a different slave, and it must go to the old slave, not the new one. The bench runs a command sequence that repeats a slave, then changes slave both for a read and for a write. A behavioural slave model logs every enable window: its slave index, the bits received and the edge count. The order of windows, including the inserted release frame, can then be checked against the bench's own record of which slave was addressed last.

// File: rtl/tps_pkg.sv
`timescale 1ns/1ps
package tps_pkg;
    localparam int FRAME_BITS = 32;
    localparam int DATA_EDGES = 33;
    localparam int PAYLOAD_W  = 24;
    localparam int REG_W      = 5;
    localparam int CHIP_W     = 3;

    localparam logic [CHIP_W-1:0] CHIP_LOCAL   = 3'b000;
    localparam logic [CHIP_W-1:0] CHIP_FOREIGN = 3'b111;
    localparam logic [REG_W-1:0]  REG_RDPTR    = 5'd0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RELEASE,
        ST_REL_GAP,
        ST_WRITE,
        ST_RD_ADDR,
        ST_RD_GAP,
        ST_RD_DATA,
        ST_TAIL
    } st_t;

    function automatic logic [FRAME_BITS-1:0] mk_frame(
        input logic [PAYLOAD_W-1:0] payload,
        input logic [REG_W-1:0]     rg,
        input logic [CHIP_W-1:0]    chip
    );
        return {payload, rg, chip};
    endfunction
endpackage

// File: rtl/tps_clkdiv.sv
`timescale 1ns/1ps
module tps_clkdiv #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tps_shifter.sv
`timescale 1ns/1ps
module tps_shifter
    import tps_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] word,
    input  logic                  long_frame,
    input  logic                  tick,
    input  logic                  miso,
    output logic                  active,
    output logic                  done,
    output logic                  sclk,
    output logic                  mosi,
    output logic [FRAME_BITS:0]   rx
);
    logic                low_half;
    logic [5:0]          bitn;
    logic                long_q;
    logic [FRAME_BITS:0] tx;
    logic [5:0]          nb;

    assign nb   = long_q ? 6'(DATA_EDGES) : 6'(FRAME_BITS);
    assign done = active && tick && !low_half && (bitn == nb);
    assign sclk = !low_half;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            low_half <= 1'b0;
            bitn     <= '0;
            long_q   <= 1'b0;
            tx       <= '0;
            rx       <= '0;
            mosi     <= 1'b0;
        end else if (start) begin
            active   <= 1'b1;
            low_half <= 1'b0;
            bitn     <= '0;
            long_q   <= long_frame;
            tx       <= {word, 1'b0};
            rx       <= '0;
        end else if (active && tick) begin
            if (!low_half) begin
                if (bitn == nb) begin
                    active <= 1'b0;
                end else begin
                    low_half <= 1'b1;
                    mosi     <= tx[FRAME_BITS];
                    tx       <= {tx[FRAME_BITS-1:0], 1'b0};
                end
            end else begin
                low_half <= 1'b0;
                rx       <= {rx[FRAME_BITS-1:0], miso};
                bitn     <= bitn + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tps_sel_decode.sv
`timescale 1ns/1ps
module tps_sel_decode #(
    parameter int NUM_SLV = 4,
    parameter int SW      = 2
) (
    input  logic          en_on,
    input  logic [SW-1:0] sel,
    output logic [NUM_SLV-1:0] slv_en
);
    for (genvar i = 0; i < NUM_SLV; i++) begin : g_en
        assign slv_en[i] = en_on && (sel == SW'(i));
    end
endmodule

// File: rtl/twophase_spi_master.sv
`timescale 1ns/1ps
module twophase_spi_master
    import tps_pkg::*;
#(
    parameter int NUM_SLV = 4,
    parameter int CLK_DIV = 4,
    parameter int GAP_CYC = 2,
    localparam int SW     = (NUM_SLV > 1) ? $clog2(NUM_SLV) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic               cmd_read,
    input  logic [SW-1:0]      cmd_slave,
    input  logic [4:0]         cmd_reg,
    input  logic [23:0]        cmd_wdata,
    output logic               rsp_valid,
    output logic               rsp_is_read,
    output logic               rsp_lock,
    output logic [31:0]        rsp_data,
    output logic               sclk,
    output logic               mosi,
    input  logic               miso,
    output logic [NUM_SLV-1:0] slv_en
);
    localparam int GW = $clog2(GAP_CYC + 1);

    st_t state, nstate;

    logic [GW-1:0]  gcnt;
    logic           gap_end;
    logic           c_read;
    logic [SW-1:0]  c_slave;
    logic [4:0]     c_reg;
    logic [23:0]    c_wdata;
    logic [SW-1:0]  owner;
    logic           owner_vld;

    logic           e_read;
    logic [SW-1:0]  e_slave;
    logic [4:0]     e_reg;
    logic [23:0]    e_wdata;

    logic           sh_start;
    logic           sh_long;
    logic [31:0]    sh_word;
    logic           sh_active;
    logic           sh_done;
    logic [32:0]    sh_rx;
    logic           tick;
    logic           en_on;
    logic [SW-1:0]  en_sel;

    // Effective command fields: live inputs while idle, latched copy otherwise
    always_comb begin
        if (state == ST_IDLE) begin
            e_read  = cmd_read;
            e_slave = cmd_slave;
            e_reg   = cmd_reg;
            e_wdata = cmd_wdata;
        end else begin
            e_read  = c_read;
            e_slave = c_slave;
            e_reg   = c_reg;
            e_wdata = c_wdata;
        end
    end

    assign gap_end = (gcnt == GW'(GAP_CYC - 1));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nstate;
        end
    end

    // Next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (owner_vld && (owner != cmd_slave)) begin
                        nstate = ST_RELEASE;
                    end else if (cmd_read) begin
                        nstate = ST_RD_ADDR;
                    end else begin
                        nstate = ST_WRITE;
                    end
                end
            end
            ST_RELEASE: if (sh_done) nstate = ST_REL_GAP;
            ST_REL_GAP: if (gap_end) nstate = e_read ? ST_RD_ADDR : ST_WRITE;
            ST_WRITE:   if (sh_done) nstate = ST_TAIL;
            ST_RD_ADDR: if (sh_done) nstate = ST_RD_GAP;
            ST_RD_GAP:  if (gap_end) nstate = ST_RD_DATA;
            ST_RD_DATA: if (sh_done) nstate = ST_TAIL;
            ST_TAIL:    if (gap_end) nstate = ST_IDLE;
            default:    nstate = ST_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        sh_start = 1'b0;
        sh_long  = 1'b0;
        sh_word  = '0;
        if (nstate != state) begin
            unique case (nstate)
                ST_RELEASE: begin
                    sh_start = 1'b1;
                    sh_word  = mk_frame('0, REG_RDPTR, CHIP_FOREIGN);
                end
                ST_WRITE: begin
                    sh_start = 1'b1;
                    sh_word  = mk_frame(e_wdata, e_reg, CHIP_LOCAL);
                end
                ST_RD_ADDR: begin
                    sh_start = 1'b1;
                    sh_word  = mk_frame({19'b0, e_reg}, REG_RDPTR, CHIP_LOCAL);
                end
                ST_RD_DATA: begin
                    sh_start = 1'b1;
                    sh_long  = 1'b1;
                    sh_word  = mk_frame({19'b0, e_reg}, REG_RDPTR, CHIP_LOCAL);
                end
                default: ;
            endcase
        end
        en_on     = (state == ST_RELEASE) || (state == ST_WRITE) ||
                    (state == ST_RD_ADDR) || (state == ST_RD_DATA);
        en_sel    = (state == ST_RELEASE) ? owner : c_slave;
        cmd_ready = (state == ST_IDLE);
    end

    // Pause counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gcnt <= '0;
        end else if ((state == ST_REL_GAP) || (state == ST_RD_GAP) || (state == ST_TAIL)) begin
            gcnt <= gap_end ? '0 : gcnt + 1'b1;
        end else begin
            gcnt <= '0;
        end
    end

    // Command latch and owner tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_read    <= 1'b0;
            c_slave   <= '0;
            c_reg     <= '0;
            c_wdata   <= '0;
            owner     <= '0;
            owner_vld <= 1'b0;
        end else begin
            if ((state == ST_IDLE) && cmd_valid) begin
                c_read  <= cmd_read;
                c_slave <= cmd_slave;
                c_reg   <= cmd_reg;
                c_wdata <= cmd_wdata;
            end
            if (sh_start && ((nstate == ST_WRITE) || (nstate == ST_RD_ADDR))) begin
                owner     <= e_slave;
                owner_vld <= 1'b1;
            end
        end
    end

    // Response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_is_read <= 1'b0;
            rsp_lock    <= 1'b0;
            rsp_data    <= '0;
        end else if ((state == ST_RD_DATA) && sh_done) begin
            rsp_valid   <= 1'b1;
            rsp_is_read <= 1'b1;
            rsp_lock    <= sh_rx[32];
            rsp_data    <= sh_rx[31:0];
        end else if ((state == ST_WRITE) && sh_done) begin
            rsp_valid   <= 1'b1;
            rsp_is_read <= 1'b0;
            rsp_lock    <= 1'b0;
            rsp_data    <= '0;
        end else begin
            rsp_valid   <= 1'b0;
        end
    end

    tps_clkdiv #(.CLK_DIV(CLK_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (sh_active),
        .tick  (tick)
    );

    tps_shifter u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (sh_start),
        .word       (sh_word),
        .long_frame (sh_long),
        .tick       (tick),
        .miso       (miso),
        .active     (sh_active),
        .done       (sh_done),
        .sclk       (sclk),
        .mosi       (mosi),
        .rx         (sh_rx)
    );

    tps_sel_decode #(.NUM_SLV(NUM_SLV), .SW(SW)) u_dec (
        .en_on  (en_on),
        .sel    (en_sel),
        .slv_en (slv_en)
    );
endmodule

// File: rtl/tps_checker.sv
`timescale 1ns/1ps
module tps_checker #(
    parameter int NUM_SLV = 4,
    parameter int GAP_CYC = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sclk,
    input logic               mosi,
    input logic [NUM_SLV-1:0] slv_en,
    input logic               cmd_ready,
    input logic               rsp_valid,
    input logic               rsp_is_read,
    input logic               rsp_lock,
    input logic [31:0]        rsp_data
);
    localparam int GW = $clog2(GAP_CYC + 1);
    logic [GW-1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= GW'(GAP_CYC);
        end else if (|slv_en) begin
            idle_cnt <= '0;
        end else if (idle_cnt != GW'(GAP_CYC)) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    a_r1_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_en == '0) |-> sclk);
    a_r1_en_edges_high: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(|slv_en) || $fell(|slv_en)) |-> sclk);
    a_r2_mosi_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi) |-> $fell(sclk));
    a_r7_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slv_en));
    a_r8_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|slv_en) |-> (idle_cnt >= GW'(GAP_CYC)));
    a_r6_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    a_r6_write_rsp_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_is_read) |-> ((rsp_data == '0) && !rsp_lock));
    a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ((|slv_en) || rsp_valid) |-> !cmd_ready);
endmodule

bind twophase_spi_master tps_checker #(.NUM_SLV(NUM_SLV), .GAP_CYC(GAP_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk        (sclk),
    .mosi        (mosi),
    .slv_en      (slv_en),
    .cmd_ready   (cmd_ready),
    .rsp_valid   (rsp_valid),
    .rsp_is_read (rsp_is_read),
    .rsp_lock    (rsp_lock),
    .rsp_data    (rsp_data)
);

// File: tb/twophase_spi_master_tb.sv
`timescale 1ns/1ps
module twophase_spi_master_tb;
    localparam int NS   = 4;
    localparam int DIV  = 4;
    localparam int GAP  = 2;
    localparam int HALF = DIV / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        cmd_valid = 1'b0, cmd_ready, cmd_read = 1'b0;
    logic [1:0]  cmd_slave = '0;
    logic [4:0]  cmd_reg = '0;
    logic [23:0] cmd_wdata = '0;
    logic        rsp_valid, rsp_is_read, rsp_lock;
    logic [31:0] rsp_data;
    logic        sclk, mosi, miso;
    logic [NS-1:0] slv_en;

    twophase_spi_master #(.NUM_SLV(NS), .CLK_DIV(DIV), .GAP_CYC(GAP)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_read(cmd_read), .cmd_slave(cmd_slave), .cmd_reg(cmd_reg),
        .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_is_read(rsp_is_read),
        .rsp_lock(rsp_lock), .rsp_data(rsp_data), .sclk(sclk), .mosi(mosi),
        .miso(miso), .slv_en(slv_en)
    );

    int checks = 0, fails = 0;
    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Behavioural slave model and window log
    logic any_en;
    assign any_en = |slv_en;
    logic miso_r = 1'b1;
    assign miso = miso_r;
    int          cur = 0;
    logic [32:0] sh = '0;
    int          nb = 0;
    bit          in_data = 0;
    logic [32:0] out_sh = '0;
    bit          rd_pend [NS];
    logic        lock_m  [NS];
    logic [31:0] data_m  [NS];
    int          log_idx [64];
    logic [31:0] log_word[64];
    logic        log_last[64];
    int          log_nb  [64];
    int          log_n = 0;

    function automatic int en_index();
        for (int i = 0; i < NS; i++) if (slv_en[i]) return i;
        return -1;
    endfunction

    always @(posedge any_en) begin
        cur = en_index();
        sh = '0;
        nb = 0;
        in_data = rd_pend[cur];
        if (in_data) begin
            out_sh = {lock_m[cur], data_m[cur]};
            miso_r = out_sh[32];
        end
    end

    always @(posedge sclk) begin
        if (any_en) begin
            sh = {sh[31:0], mosi};
            nb++;
            if (in_data) begin
                #1;
                out_sh = {out_sh[31:0], 1'b0};
                miso_r = out_sh[32];
            end
        end
    end

    always @(negedge any_en) begin
        if (log_n < 64) begin
            log_idx[log_n]  = cur;
            log_word[log_n] = (nb == 33) ? sh[32:1] : sh[31:0];
            log_last[log_n] = sh[0];
            log_nb[log_n]   = nb;
            log_n++;
        end
        if (in_data) rd_pend[cur] = 0;
        else if (nb == 32 && sh[7:0] == 8'h00) rd_pend[cur] = 1;
        in_data = 0;
        miso_r = 1'b1;
    end

    // Pin-level monitors sampled away from the active edge
    int idle_bad = 0, run_bad = 0, onehot_bad = 0;
    int hi = 0, lo = 0, gapc = 0, min_gap = 1000;
    bit prev_en = 0, seen_win = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!any_en && !sclk) idle_bad++;
            if ($countones(slv_en) > 1) onehot_bad++;
            if (any_en) begin
                if (!prev_en) begin
                    hi = 0; lo = 0;
                    if (seen_win && gapc < min_gap) min_gap = gapc;
                    seen_win = 1;
                end
                if (sclk) begin
                    if (lo != 0) begin if (lo != HALF) run_bad++; lo = 0; end
                    hi++;
                end else begin
                    if (hi != 0) begin if (hi != HALF) run_bad++; hi = 0; end
                    lo++;
                end
                gapc = 0;
            end else begin
                if (prev_en) begin if (hi != HALF) run_bad++; hi = 0; end
                gapc++;
            end
            prev_en = any_en;
        end
    end

    // Watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    int exp_owner = -1;

    task automatic do_cmd(input bit rd, input int s, input logic [4:0] rg,
                          input logic [23:0] wd, output logic r_is,
                          output logic r_lock, output logic [31:0] r_data);
        int  guard = 0;
        bit  got = 0;
        int  ready_bad = 0;
        @(negedge clk);
        while (!cmd_ready && guard < 5000) begin @(negedge clk); guard++; end
        cmd_valid = 1'b1; cmd_read = rd; cmd_slave = 2'(s); cmd_reg = rg; cmd_wdata = wd;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        cmd_wdata = 24'h5A5A5A; cmd_reg = 5'h1F; cmd_read = ~rd;
        guard = 0;
        r_is = 1'b0; r_lock = 1'b0; r_data = '0;
        while (!got && guard < 5000) begin
            @(negedge clk);
            guard++;
            if (rsp_valid) begin
                got = 1; r_is = rsp_is_read; r_lock = rsp_lock; r_data = rsp_data;
            end
            if (cmd_ready) ready_bad++;
        end
        chk(got, "R6", "response seen", 64'(got), 1);
        chk(ready_bad == 0, "R10", "ready low until response", 64'(ready_bad), 0);
        @(negedge clk);
        chk(!rsp_valid, "R6", "response one cycle", 64'(rsp_valid), 0);
    endtask

    task automatic check_release(input int s, inout int k);
        if (exp_owner >= 0 && exp_owner != s) begin
            chk(log_idx[k] == exp_owner, "R9", "release slave", 64'(log_idx[k]), 64'(exp_owner));
            chk(log_word[k] == 32'h0000_0007 && log_nb[k] == 32, "R9", "release word",
                64'(log_word[k]), 64'h7);
            k++;
        end
    endtask

    task automatic t_write(input int s, input logic [4:0] rg, input logic [23:0] d);
        logic ri, rl; logic [31:0] rdt;
        int k = log_n;
        int n0 = log_n;
        do_cmd(0, s, rg, d, ri, rl, rdt);
        check_release(s, k);
        chk(log_n == k + 1, "R9", "window count write", 64'(log_n - n0), 64'(k + 1 - n0));
        chk(log_idx[k] == s, "R7", "write slave", 64'(log_idx[k]), 64'(s));
        chk(log_word[k] == {d, rg, 3'b000} && log_nb[k] == 32, "R3", "write frame",
            64'(log_word[k]), 64'({d, rg, 3'b000}));
        chk(!ri && !rl && rdt == 0, "R6", "write response empty", {31'b0, ri, rl, rdt}, 0);
        exp_owner = s;
    endtask

    task automatic t_read(input int s, input logic [4:0] rg, input logic lk,
                          input logic [31:0] d);
        logic ri, rl; logic [31:0] rdt;
        int k = log_n;
        int n0 = log_n;
        logic [31:0] aw = {19'b0, rg, 8'h00};
        lock_m[s] = lk; data_m[s] = d;
        do_cmd(1, s, rg, 24'h0, ri, rl, rdt);
        check_release(s, k);
        chk(log_n == k + 2, "R4", "window count read", 64'(log_n - n0), 64'(k + 2 - n0));
        chk(log_idx[k] == s && log_idx[k+1] == s, "R7", "read slave", 64'(log_idx[k+1]), 64'(s));
        chk(log_word[k] == aw && log_nb[k] == 32, "R4", "address frame", 64'(log_word[k]), 64'(aw));
        chk(log_nb[k+1] == 33, "R4", "data window edges", 64'(log_nb[k+1]), 33);
        chk(log_word[k+1] == aw && log_last[k+1] == 1'b0, "R4", "data window mosi",
            64'(log_word[k+1]), 64'(aw));
        chk(ri && rl == lk, "R5", "read lock", {62'b0, ri, rl}, {62'b0, 1'b1, lk});
        chk(rdt == d, "R5", "read data", 64'(rdt), 64'(d));
        exp_owner = s;
    endtask

    initial begin
        for (int i = 0; i < NS; i++) begin rd_pend[i] = 0; lock_m[i] = 0; data_m[i] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(cmd_ready && sclk && !mosi && slv_en == 0 && !rsp_valid, "R11", "reset state",
            {59'b0, cmd_ready, sclk, mosi, |slv_en, rsp_valid}, 64'b11000);
        t_write(0, 5'h05, 24'hA1B2C3);      // first command: no release
        t_write(0, 5'h1E, 24'h000001);      // same slave: no release
        t_read (0, 5'h02, 1'b1, 32'hDEADBEEF);
        t_read (1, 5'h07, 1'b0, 32'h12345678); // switch: release to slave 0
        t_write(2, 5'h1F, 24'hFFFFFF);      // switch: release to slave 1
        t_read (2, 5'h01, 1'b0, 32'hFFFFFFFF);
        t_read (3, 5'h10, 1'b1, 32'h80000001);
        t_write(1, 5'h03, 24'h000000);
        repeat (10) @(negedge clk);
        chk(idle_bad == 0, "R1", "sclk high when idle", 64'(idle_bad), 0);
        chk(run_bad == 0, "R2", "half period runs", 64'(run_bad), 0);
        chk(onehot_bad == 0, "R7", "single enable", 64'(onehot_bad), 0);
        chk(min_gap >= GAP, "R8", "minimum enable gap", 64'(min_gap), 64'(GAP));
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule